// File: doc/BRIEF.md
# Byte-Register Window to a Wide Memory Space

This block gives a host with only a narrow, byte-wide register bus a way to reach a 32-bit memory space. It takes up five consecutive byte locations in the host's address space. Four of them are address bytes. The fifth is a data port. Each host read or write of the data port becomes one byte-wide cycle on the memory side, at the address held in the four address bytes.

The window's location is a 16-bit base value. A separate configuration port writes it one byte at a time. The address bytes are stored least significant byte first. The base value is loaded most significant byte first. The address bytes hold their values until the host rewrites them, so sweeping through a region usually means rewriting one byte between data accesses.

A data access stalls the host through a ready signal until the memory side acknowledges the cycle. The memory may insert any number of wait cycles. Host accesses that fall outside the window get no response.

Top module: `ioport_window`

## Requirements
- R1: After reset, every address byte reads 0, the window sits at base `RST_BASE` (default 0x0300), `mem_req` is low and `hst_rdy` is low.
- R2: With the sequencer idle, a write to window offset k (k = 0..3) loads memory address bits [8k+7:8k] from `hst_wdata`. A read of that offset returns the stored byte. In both cases `hst_rdy` is high combinationally in the same cycle.
- R3: Writing one address byte leaves the other three address bytes unchanged.
- R4: A configuration write with `cfg_lo`=0 loads base bits 15:8, and one with `cfg_lo`=1 loads base bits 7:0. Once loaded, the window responds at the new base.
- R5: A host write to offset 4 starts a memory cycle with `mem_we`=1 and `mem_wdata` equal to the host byte. `mem_addr` is the assembled address, with offset 0 as the least significant byte.
- R6: A host read of offset 4 starts a memory cycle with `mem_we`=0. It returns the `mem_rdata` byte that was present alongside `mem_ack`.
- R7: During a data access `hst_rdy` stays low. It rises in the cycle after the one in which `mem_ack` is sampled, which is also when `mem_req` falls. With a memory that waits w cycles, the host therefore waits w+2 cycles.
- R8: A data access does not change the address: repeated data accesses go to the same memory address.
- R9: A host access outside base..base+4 gets no `hst_rdy`, starts no memory cycle and changes no register.
- R10: While `mem_req` is high and unacknowledged, `mem_addr`, `mem_we` and `mem_wdata` stay stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_addr | input | 16 | Host I/O address |
| hst_rd | input | 1 | Host read request, held until `hst_rdy` |
| hst_wr | input | 1 | Host write request, held until `hst_rdy` |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Host read byte, valid with `hst_rdy` |
| hst_rdy | output | 1 | Access completes at the next clock edge |
| cfg_we | input | 1 | Base byte write strobe |
| cfg_lo | input | 1 | 0 selects base high byte, 1 selects low byte |
| cfg_wdata | input | 8 | Base byte value |
| mem_req | output | 1 | Memory cycle pending |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid with `mem_ack` |
| mem_ack | input | 1 | Memory cycle complete |

## Verification
Each internal state fault shows up at the ports within a few cycles:

- **Corrupted address byte.** It shows on `mem_addr` at the very next data access. It also shows on the same-cycle readback of that offset.
- **Stuck sequencer.** A sequencer that never leaves its busy state shows as `hst_rdy` never rising.
- **Sequencer that leaves too early.** It shows as a wait count shorter than w+2, or as a wrong byte returned from a read.
- **Wrong base decode.** It shows on the first access that lands just inside or just outside the window edge. The symptom is either a spurious `hst_rdy` or a missing one.

// File: rtl/ioport_pkg.sv
package ioport_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_BUSY = 2'd1,
    SQ_DONE = 2'd2
  } seq_st_t;
endpackage

// File: rtl/ioport_decode.sv
module ioport_decode #(
  parameter int HAW  = 16,
  parameter int NREG = 5,
  localparam int OFF_W = $clog2(NREG)
) (
  input  logic [HAW-1:0]   base,
  input  logic [HAW-1:0]   addr,
  output logic             hit,
  output logic [OFF_W-1:0] off
);
  localparam logic [HAW:0] LIM = (HAW+1)'(NREG);

  logic [HAW:0] diff;

  always_comb begin
    diff = {1'b0, addr} - {1'b0, base};
    hit  = !diff[HAW] && (diff < LIM);
    off  = diff[OFF_W-1:0];
  end
endmodule

// File: rtl/ioport_regs.sv
module ioport_regs #(
  parameter int              DW       = 8,
  parameter int              NAB      = 4,
  parameter int              HAW      = 16,
  parameter logic [HAW-1:0]  RST_BASE = 16'h0300,
  localparam int             AW       = NAB * DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NAB-1:0]  ab_we,
  input  logic [DW-1:0]   ab_wdata,
  input  logic            cfg_we,
  input  logic            cfg_lo,
  input  logic [DW-1:0]   cfg_wdata,
  output logic [AW-1:0]   maddr,
  output logic [HAW-1:0]  base
);
  // Address bytes: least significant first.
  for (genvar i = 0; i < NAB; i++) begin : g_ab
    logic [DW-1:0] ab_q, ab_d;

    always_comb begin
      ab_d = ab_q;
      if (ab_we[i]) ab_d = ab_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ab_q <= '0;
      else        ab_q <= ab_d;
    end

    assign maddr[i*DW +: DW] = ab_q;
  end

  // Base value: loaded most significant byte first (cfg_lo = 0 -> high).
  logic [DW-1:0] bhi_q, bhi_d, blo_q, blo_d;

  always_comb begin
    bhi_d = bhi_q;
    blo_d = blo_q;
    if (cfg_we && !cfg_lo) bhi_d = cfg_wdata;
    if (cfg_we &&  cfg_lo) blo_d = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bhi_q <= RST_BASE[HAW-1 -: DW];
      blo_q <= RST_BASE[DW-1:0];
    end else begin
      bhi_q <= bhi_d;
      blo_q <= blo_d;
    end
  end

  assign base = {bhi_q, blo_q};
endmodule

// File: rtl/ioport_seq.sv
module ioport_seq
  import ioport_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_we,
  input  logic [DW-1:0] go_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          idle,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] rdata
);
  seq_st_t       st_q, st_d;
  logic          we_q, we_d;
  logic [DW-1:0] wd_q, wd_d, rd_q, rd_d;

  always_comb begin
    st_d = st_q;
    we_d = we_q;
    wd_d = wd_q;
    rd_d = rd_q;
    unique case (st_q)
      SQ_IDLE: if (go) begin
        st_d = SQ_BUSY;
        we_d = go_we;
        wd_d = go_wdata;
      end
      SQ_BUSY: if (mem_ack) begin
        st_d = SQ_DONE;
        rd_d = mem_rdata;
      end
      SQ_DONE: st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE;
      we_q <= 1'b0;
      wd_q <= '0;
      rd_q <= '0;
    end else begin
      st_q <= st_d;
      we_q <= we_d;
      wd_q <= wd_d;
      rd_q <= rd_d;
    end
  end

  assign idle      = (st_q == SQ_IDLE);
  assign done      = (st_q == SQ_DONE);
  assign mem_req   = (st_q == SQ_BUSY);
  assign mem_we    = we_q;
  assign mem_wdata = wd_q;
  assign rdata     = rd_q;

  // R5: a launch from idle raises the memory request next cycle
  p_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && go) |=> mem_req);

  // R10: request attributes hold while the memory waits
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_wdata)));

  // R7: an acknowledged request ends and the host is released next
  p_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (done && !mem_req));
endmodule

// File: rtl/ioport_window.sv
module ioport_window #(
  parameter int             DW       = 8,
  parameter int             NAB      = 4,
  parameter int             HAW      = 16,
  parameter logic [15:0]    RST_BASE = 16'h0300
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [HAW-1:0]      hst_addr,
  input  logic                hst_rd,
  input  logic                hst_wr,
  input  logic [DW-1:0]       hst_wdata,
  output logic [DW-1:0]       hst_rdata,
  output logic                hst_rdy,
  input  logic                cfg_we,
  input  logic                cfg_lo,
  input  logic [DW-1:0]       cfg_wdata,
  output logic                mem_req,
  output logic                mem_we,
  output logic [NAB*DW-1:0]   mem_addr,
  output logic [DW-1:0]       mem_wdata,
  input  logic [DW-1:0]       mem_rdata,
  input  logic                mem_ack
);
  localparam int              NREG     = NAB + 1;
  localparam int              OFF_W    = $clog2(NREG);
  localparam logic [OFF_W-1:0] DATA_OFF = OFF_W'(NAB);

  logic [HAW-1:0]   base;
  logic             hit;
  logic [OFF_W-1:0] off;
  logic             idle, done, hst_any, is_data, go, reg_acc;
  logic [NAB-1:0]   ab_we;
  logic [DW-1:0]    seq_rdata, ab_rdata;

  ioport_decode #(.HAW(HAW), .NREG(NREG)) u_dec (
    .base (base),
    .addr (hst_addr),
    .hit  (hit),
    .off  (off)
  );

  always_comb begin
    hst_any = hst_rd || hst_wr;
    is_data = hit && (off == DATA_OFF);
    go      = idle && hst_any && is_data;
    reg_acc = idle && hst_any && hit && !is_data;
  end

  for (genvar i = 0; i < NAB; i++) begin : g_we
    assign ab_we[i] = reg_acc && hst_wr && (off == OFF_W'(i));
  end

  ioport_regs #(.DW(DW), .NAB(NAB), .HAW(HAW), .RST_BASE(HAW'(RST_BASE))) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ab_we     (ab_we),
    .ab_wdata  (hst_wdata),
    .cfg_we    (cfg_we),
    .cfg_lo    (cfg_lo),
    .cfg_wdata (cfg_wdata),
    .maddr     (mem_addr),
    .base      (base)
  );

  ioport_seq #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .go_we     (hst_wr),
    .go_wdata  (hst_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .idle      (idle),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .rdata     (seq_rdata)
  );

  always_comb begin
    ab_rdata = '0;
    for (int k = 0; k < NAB; k++) begin
      if (off == OFF_W'(k)) ab_rdata = mem_addr[k*DW +: DW];
    end
  end

  assign hst_rdy   = reg_acc || done;
  assign hst_rdata = done ? seq_rdata : ((reg_acc && hst_rd) ? ab_rdata : '0);

  // R7: the host is held off while the memory cycle is pending
  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !hst_rdy);

  // R10: the memory address holds while the memory waits
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> $stable(mem_addr));

  // R8: completing a data cycle leaves the address untouched
  p_no_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> $stable(mem_addr));

  // R9: an access outside the window starts nothing
  p_miss_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && hst_any && !hit) |=> !mem_req);
endmodule

// File: tb/sim_ioport_window.sv
`timescale 1ns/1ps
module sim_ioport_window;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] hst_addr;
  logic        hst_rd, hst_wr;
  logic [7:0]  hst_wdata, hst_rdata;
  logic        hst_rdy;
  logic        cfg_we, cfg_lo;
  logic [7:0]  cfg_wdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        mem_ack;

  always #10 clk = ~clk;  // 50 MHz

  ioport_window u0 (
    .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_rd(hst_rd), .hst_wr(hst_wr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_rdy(hst_rdy),
    .cfg_we(cfg_we), .cfg_lo(cfg_lo), .cfg_wdata(cfg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Memory model
  int          mwait = 0;
  int          mcnt  = 0;
  int          nmem  = 0;
  logic [31:0] last_wa, last_ra;
  logic [7:0]  last_wd;

  function automatic logic [7:0] mfun(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h5A;
  endfunction

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
      mcnt    <= 0;
    end else if (mem_req) begin
      if (mcnt >= mwait) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mfun(mem_addr);
        nmem      <= nmem + 1;
        if (mem_we) begin
          last_wa <= mem_addr;
          last_wd <= mem_wdata;
        end else begin
          last_ra <= mem_addr;
        end
      end else begin
        mcnt <= mcnt + 1;
      end
    end else begin
      mcnt <= 0;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hacc(input logic w, input logic [15:0] a, input logic [7:0] d, input int lim,
                      output logic [7:0] rd, output int waits, output logic ok);
    @(negedge clk);
    hst_addr = a; hst_wr = w; hst_rd = !w; hst_wdata = d;
    ok = 1'b0; waits = 0; rd = '0;
    for (int k = 0; k < lim; k++) begin
      #1;
      if (hst_rdy) begin
        ok = 1'b1;
        rd = hst_rdata;
        break;
      end
      waits++;
      @(negedge clk);
    end
    if (ok) begin
      @(posedge clk);
      #1;
    end
    hst_wr = 1'b0; hst_rd = 1'b0;
  endtask

  task automatic cfgw(input logic lo, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_lo = lo; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Vector: op[37:36] (0 reg wr, 1 reg rd, 2 data wr, 3 data rd), addr[35:20], wdata[19:12], exp[11:4], req[3:0]
  localparam logic [37:0] VEC [12] = '{
    {2'd0, 16'h0300, 8'h78, 8'h00, 4'd2},  // R2 byte 0
    {2'd0, 16'h0301, 8'h56, 8'h00, 4'd2},
    {2'd0, 16'h0302, 8'h34, 8'h00, 4'd2},
    {2'd0, 16'h0303, 8'h12, 8'h00, 4'd2},
    {2'd1, 16'h0300, 8'h00, 8'h78, 4'd2},  // R2 readback
    {2'd1, 16'h0303, 8'h00, 8'h12, 4'd2},
    {2'd2, 16'h0304, 8'hA5, 8'h00, 4'd5},  // R5 data write
    {2'd3, 16'h0304, 8'h00, 8'h00, 4'd6},  // R6 data read
    {2'd0, 16'h0301, 8'h9A, 8'h00, 4'd3},  // R3 partial update
    {2'd1, 16'h0302, 8'h00, 8'h34, 4'd3},  // R3 neighbours kept
    {2'd3, 16'h0304, 8'h00, 8'h00, 4'd6},
    {2'd3, 16'h0304, 8'h00, 8'h00, 4'd8}   // R8 same address again
  };

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0]  sh [4];
    logic [7:0]  rd;
    logic [31:0] sa;
    int          wt, n0;
    logic        ok;
    string       tg;

    rst_n = 1'b0; hst_addr = '0; hst_rd = 0; hst_wr = 0; hst_wdata = '0;
    cfg_we = 0; cfg_lo = 0; cfg_wdata = '0; mem_ack = 0; mem_rdata = '0;
    for (int i = 0; i < 4; i++) sh[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(!mem_req && !hst_rdy, "R1 outputs in reset", {mem_req, hst_rdy}, 0);
    chk(mem_addr == 32'h0, "R1 address in reset", mem_addr, 0);
    rst_n = 1'b1;
    hacc(1'b0, 16'h0302, 8'h00, 10, rd, wt, ok);
    chk(ok && rd == 8'h00, "R1 byte 2 after reset at 0x0300", rd, 0);

    // Vector walk
    for (int v = 0; v < 12; v++) begin
      logic [1:0]  op;
      logic [15:0] a;
      logic [7:0]  wd, ex;
      op = VEC[v][37:36]; a = VEC[v][35:20]; wd = VEC[v][19:12]; ex = VEC[v][11:4];
      tg = $sformatf("R%0d vec %0d", VEC[v][3:0], v);
      sa = {sh[3], sh[2], sh[1], sh[0]};
      hacc(op == 2'd0 || op == 2'd2, a, wd, 40, rd, wt, ok);
      case (op)
        2'd0: begin
          sh[a[1:0]] = wd;
          chk(ok && wt == 0, tg, wt, 0);
        end
        2'd1: chk(ok && wt == 0 && rd == ex, tg, rd, ex);
        2'd2: chk(ok && last_wa == sa && last_wd == wd, tg, last_wa, sa);
        default: chk(ok && last_ra == sa && rd == mfun(sa), tg, rd, mfun(sa));
      endcase
    end
    sa = {sh[3], sh[2], sh[1], sh[0]};
    chk(mem_addr == 32'h12349A78 && sa == 32'h12349A78, "R2 assembled little-endian", mem_addr, 32'h12349A78);

    // R7 / R10: memory wait of 3 cycles
    mwait = 3;
    hacc(1'b1, 16'h0304, 8'h3C, 40, rd, wt, ok);
    chk(ok && wt == 5, "R7 write stall w+2", wt, 5);
    chk(last_wd == 8'h3C && last_wa == sa, "R10 write data held through wait", last_wd, 8'h3C);
    hacc(1'b0, 16'h0304, 8'h00, 40, rd, wt, ok);
    chk(ok && wt == 5 && rd == mfun(sa), "R7 read stall and data", rd, mfun(sa));
    mwait = 0;
    hacc(1'b0, 16'h0304, 8'h00, 40, rd, wt, ok);
    chk(ok && wt == 2, "R7 zero-wait stall", wt, 2);

    // R9: outside the window, both edges
    n0 = nmem;
    hacc(1'b1, 16'h0305, 8'h77, 8, rd, wt, ok);
    chk(!ok, "R9 just above window no response", ok, 0);
    hacc(1'b1, 16'h02FF, 8'h77, 8, rd, wt, ok);
    chk(!ok, "R9 just below window no response", ok, 0);
    repeat (3) @(negedge clk);
    chk(nmem == n0 && !mem_req, "R9 no memory cycle", nmem, n0);
    chk(mem_addr == sa, "R9 registers unchanged", mem_addr, sa);

    // R4: move the window big-endian to 0x1240
    cfgw(1'b0, 8'h12);
    cfgw(1'b1, 8'h40);
    hacc(1'b0, 16'h0300, 8'h00, 8, rd, wt, ok);
    chk(!ok, "R4 old base no longer answers", ok, 0);
    hacc(1'b0, 16'h1243, 8'h00, 10, rd, wt, ok);
    chk(ok && rd == 8'h12, "R4 new base readback", rd, 8'h12);
    hacc(1'b1, 16'h1240, 8'hEE, 10, rd, wt, ok);
    sa = {sh[3], sh[2], sh[1], 8'hEE};
    n0 = nmem;
    hacc(1'b1, 16'h1244, 8'h11, 40, rd, wt, ok);
    chk(ok && last_wa == sa && nmem == n0 + 1, "R4 data port at new base", last_wa, sa);
    hacc(1'b0, 16'h123F, 8'h00, 8, rd, wt, ok);
    chk(!ok, "R9 below new base", ok, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule